// File: doc/BRIEF.md
# Home Node Write Arbiter

This block is the control logic a line's home node runs when coherence is kept as a tree of links inside the network. The home node keeps no list of sharers. It keeps a mask with one bit for each neighbouring port that is a tree link, and it keeps the port that leads toward the current tree root. Every request that arrives at home goes through a small arrival-ordered queue. The state machine takes requests from that queue one at a time. A read is forwarded toward the root when a tree exists. Otherwise the line is fetched from off-chip memory and returned to the requester. A write with no tree is granted at once. A write that finds a tree first sends teardown messages along every link. It then waits, with its busy state held, until the acknowledgments have emptied the link mask, and only then grants the write. A requester that receives data from memory, or that receives a write grant, becomes the new root, and home builds its link toward that requester.

Only one operation is in flight at a time. Requests that arrive while an operation is outstanding wait in the queue. A full queue back-pressures the sender by lowering `reqReady`. All outgoing traffic leaves on one registered message bus, which is valid for one cycle per message.

Top module: `home_write_arbiter`

## Requirements
- R1: After reset no tree exists, `reqReady` is 1, and both `msgValid` and `memReqValid` are 0.
- R2: When a tree exists, a read taken from the queue produces one message of kind 2 (forward). Its `msgDirMask` is one-hot on the root port and its `msgDest` is the requester. The link mask does not change.
- R3: When no tree exists, a read raises `memReqValid`. The memory response produces a kind 0 message (read data) that carries `memRspData`, is addressed to the requester, and is one-hot on the port the request came from. That port then becomes the single link and the root.
- R4: When no tree exists, a write produces a kind 1 message (write grant) exactly two cycles after the request is accepted. The grant is one-hot on the request's port, and that port becomes the single link and the root.
- R5: When a tree exists, a write produces a kind 3 message (teardown) whose `msgDirMask` equals the whole link mask, addressed to the writer.
- R6: During teardown, an acknowledgment on port d clears link bit d. The write grant is sent only after the mask is empty, and it points to the writer's port.
- R7: Queued requests are served strictly in arrival order once the current operation ends.
- R8: The queue holds 4 requests. With 4 waiting, `reqReady` is 0 and an offered request is not taken.
- R9: An acknowledgment that arrives when no teardown is in progress leaves the link mask unchanged.
- R10: While a memory fetch is outstanding, no other request is served and no message is sent until the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | Queue can take the request |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| reqSrc | input | ID_W | Requesting node identifier |
| reqDir | input | DIR_W | Home port the request arrived on |
| ackValid | input | 1 | Teardown acknowledgment arrives |
| ackDir | input | DIR_W | Port the acknowledgment arrived on |
| memReqValid | output | 1 | Off-chip read request |
| memReqReady | input | 1 | Memory takes the read request |
| memRspValid | input | 1 | Memory data is returned (one cycle) |
| memRspData | input | DATA_W | Returned line data |
| msgValid | output | 1 | Outgoing message valid (one cycle) |
| msgKind | output | 2 | 0 read data, 1 write grant, 2 forward, 3 teardown |
| msgDirMask | output | 2**DIR_W | Ports the message leaves on |
| msgDest | output | ID_W | Requester the message concerns |
| msgData | output | DATA_W | Data for kind 0, otherwise zero |

## Verification
Reads are sent both with and without a tree. A read that goes to memory when it should be forwarded, or the reverse, shows up as the wrong message kind. Writes are also sent with and without a tree: an immediate grant is told apart from a teardown, and the bench checks that no grant leaks out before the last acknowledgment. Stray acknowledgments while idle are followed by a read, which must still be forwarded. A burst that fills the queue during a teardown is then drained, which tests both back-pressure and the order of service.

// File: rtl/hna_pkg.sv
package hna_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_TEAR  = 2'd2,
    ST_GRANT = 2'd3
  } state_t;

  localparam logic [1:0] KIND_RDATA = 2'd0;
  localparam logic [1:0] KIND_GRANT = 2'd1;
  localparam logic [1:0] KIND_FWD   = 2'd2;
  localparam logic [1:0] KIND_TEAR  = 2'd3;

  typedef struct packed {
    logic       pop;        // take queue head
    logic       emit;       // register an outgoing message
    logic [1:0] kind;       // message kind
    logic       useHead;    // message fields from queue head
    logic       buildLink;  // current requester becomes root/link
    logic       holdLinks;  // teardown in progress, acks accepted
  } strobe_t;
endpackage

// File: rtl/hna_fifo.sv
module hna_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= din;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN) push |-> !full);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty);
endmodule

// File: rtl/hna_ctrl.sv
module hna_ctrl
  import hna_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    headValid,
  input  logic    headIsWrite,
  input  logic    treeExists,
  input  logic    linkEmpty,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output logic    memReqValid,
  output strobe_t strobe
);
  state_t state, nextState;
  logic   reqSent;

  assign memReqValid = (state == ST_FETCH) && !reqSent;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (headValid) begin
          strobe.pop = 1'b1;
          if (!headIsWrite) begin
            if (treeExists) begin
              strobe.emit    = 1'b1;
              strobe.kind    = KIND_FWD;
              strobe.useHead = 1'b1;
            end else begin
              nextState = ST_FETCH;
            end
          end else if (treeExists) begin
            strobe.emit    = 1'b1;
            strobe.kind    = KIND_TEAR;
            strobe.useHead = 1'b1;
            nextState      = ST_TEAR;
          end else begin
            nextState = ST_GRANT;
          end
        end
      end
      ST_FETCH: begin
        if (reqSent && memRspValid) begin
          strobe.emit      = 1'b1;
          strobe.kind      = KIND_RDATA;
          strobe.buildLink = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      ST_TEAR: begin
        strobe.holdLinks = 1'b1;
        if (linkEmpty) nextState = ST_GRANT;
      end
      ST_GRANT: begin
        strobe.emit      = 1'b1;
        strobe.kind      = KIND_GRANT;
        strobe.buildLink = 1'b1;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqSent <= 1'b0;
    end else begin
      state <= nextState;
      if (state != ST_FETCH)                reqSent <= 1'b0;
      else if (memReqValid && memReqReady)  reqSent <= 1'b1;
    end
  end

  assert_one_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobe.pop);
  assert_mem_no_tree_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !treeExists);
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TEAR && !linkEmpty) |=> (state == ST_TEAR));
endmodule

// File: rtl/hna_dpath.sv
module hna_dpath
  import hna_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DIR_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [ID_W-1:0]       headSrc,
  input  logic [DIR_W-1:0]      headDir,
  input  logic                  ackValid,
  input  logic [DIR_W-1:0]      ackDir,
  input  logic [DATA_W-1:0]     memRspData,
  output logic                  treeExists,
  output logic                  linkEmpty,
  output logic                  msgValid,
  output logic [1:0]            msgKind,
  output logic [(1<<DIR_W)-1:0] msgDirMask,
  output logic [ID_W-1:0]       msgDest,
  output logic [DATA_W-1:0]     msgData
);
  localparam int NUM_DIR = 1 << DIR_W;
  localparam logic [NUM_DIR-1:0] ONE = NUM_DIR'(1);

  logic [NUM_DIR-1:0] linkMask;
  logic [DIR_W-1:0]   rootDir, curDir;
  logic [ID_W-1:0]    curSrc;
  logic [NUM_DIR-1:0] outMask;

  assign treeExists = |linkMask;
  assign linkEmpty  = ~treeExists;

  always_comb begin
    unique case (strobe.kind)
      KIND_FWD:  outMask = ONE << rootDir;
      KIND_TEAR: outMask = linkMask;
      default:   outMask = ONE << curDir;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkMask   <= '0;
      rootDir    <= '0;
      curDir     <= '0;
      curSrc     <= '0;
      msgValid   <= 1'b0;
      msgKind    <= '0;
      msgDirMask <= '0;
      msgDest    <= '0;
      msgData    <= '0;
    end else begin
      if (strobe.pop) begin
        curSrc <= headSrc;
        curDir <= headDir;
      end
      if (strobe.buildLink) begin
        linkMask <= ONE << curDir;
        rootDir  <= curDir;
      end else if (strobe.holdLinks && ackValid) begin
        linkMask[ackDir] <= 1'b0;
      end
      msgValid <= strobe.emit;
      if (strobe.emit) begin
        msgKind    <= strobe.kind;
        msgDirMask <= outMask;
        msgDest    <= strobe.useHead ? headSrc : curSrc;
        msgData    <= (strobe.kind == KIND_RDATA) ? memRspData : '0;
      end
    end
  end

  assert_grant_on_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.kind == KIND_GRANT) |-> (linkMask == '0));
  assert_links_shrink_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdLinks |=> ((linkMask & ~$past(linkMask)) == '0));
  assert_idle_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.holdLinks && !strobe.buildLink) |=> $stable(linkMask));
  assert_dir_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgKind != KIND_TEAR) |-> $onehot(msgDirMask));
endmodule

// File: rtl/home_write_arbiter.sv
module home_write_arbiter
  import hna_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DIR_W  = 2,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqIsWrite,
  input  logic [ID_W-1:0]       reqSrc,
  input  logic [DIR_W-1:0]      reqDir,
  input  logic                  ackValid,
  input  logic [DIR_W-1:0]      ackDir,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  input  logic                  memRspValid,
  input  logic [DATA_W-1:0]     memRspData,
  output logic                  msgValid,
  output logic [1:0]            msgKind,
  output logic [(1<<DIR_W)-1:0] msgDirMask,
  output logic [ID_W-1:0]       msgDest,
  output logic [DATA_W-1:0]     msgData
);
  localparam int QW = 1 + DIR_W + ID_W;

  strobe_t       strobe;
  logic          qFull, qEmpty, treeExists, linkEmpty;
  logic [QW-1:0] qHead;

  assign reqReady = !qFull;

  hna_fifo #(.WIDTH(QW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rstN(rstN),
    .push(reqValid && !qFull), .pop(strobe.pop),
    .din({reqIsWrite, reqDir, reqSrc}), .dout(qHead),
    .full(qFull), .empty(qEmpty)
  );

  hna_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .headValid(!qEmpty), .headIsWrite(qHead[QW-1]),
    .treeExists(treeExists), .linkEmpty(linkEmpty),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memReqValid(memReqValid), .strobe(strobe)
  );

  hna_dpath #(.ID_W(ID_W), .DIR_W(DIR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headSrc(qHead[ID_W-1:0]), .headDir(qHead[ID_W +: DIR_W]),
    .ackValid(ackValid), .ackDir(ackDir), .memRspData(memRspData),
    .treeExists(treeExists), .linkEmpty(linkEmpty),
    .msgValid(msgValid), .msgKind(msgKind), .msgDirMask(msgDirMask),
    .msgDest(msgDest), .msgData(msgData)
  );
endmodule

// File: tb/sim_home_write_arbiter.sv
module sim_home_write_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqIsWrite = 0, ackValid = 0, memRspValid = 0;
  logic        memReqReady = 1'b1;
  logic [3:0]  reqSrc = 0;
  logic [1:0]  reqDir = 0, ackDir = 0;
  logic [31:0] memRspData = 0;
  logic        reqReady, memReqValid, msgValid;
  logic [1:0]  msgKind;
  logic [3:0]  msgDirMask, msgDest;
  logic [31:0] msgData;
  int          nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  home_write_arbiter u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsWrite(reqIsWrite), .reqSrc(reqSrc), .reqDir(reqDir),
    .ackValid(ackValid), .ackDir(ackDir), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .msgValid(msgValid), .msgKind(msgKind), .msgDirMask(msgDirMask),
    .msgDest(msgDest), .msgData(msgData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishUp;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finishUp();
  end

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendReq(input bit wr, input logic [3:0] src, input logic [1:0] dir,
                         output bit taken);
    reqValid = 1'b1; reqIsWrite = wr; reqSrc = src; reqDir = dir;
    taken = reqReady;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic sendAck(input logic [1:0] dir);
    ackValid = 1'b1; ackDir = dir;
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  // polls at negedges; returns cycles waited (-1 on timeout)
  task automatic expectMsg(input string tag, input logic [1:0] kind, input logic [3:0] mask,
                           input logic [3:0] dest, input logic [31:0] data, output int waited);
    waited = -1;
    for (int i = 0; i < 12; i++) begin
      if (msgValid) begin waited = i; break; end
      @(negedge clk);
    end
    check(waited >= 0, tag, "message seen", 0, 1);
    if (waited >= 0) begin
      check(msgKind == kind, tag, "kind", msgKind, kind);
      check(msgDirMask == mask, tag, "dir mask", msgDirMask, mask);
      check(msgDest == dest, tag, "dest", msgDest, dest);
      check(msgData == data, tag, "data", msgData, data);
      @(negedge clk);
    end
  endtask

  task automatic expectQuiet(input string tag, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (msgValid) seen = 1;
      @(negedge clk);
    end
    check(!seen, tag, "no message", seen, 0);
  endtask

  // R1
  task automatic testReset;
    doReset();
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check(msgValid == 1'b0, "R1", "msgValid", msgValid, 0);
    check(memReqValid == 1'b0, "R1", "memReqValid", memReqValid, 0);
  endtask

  // R3, R10, R2, R9
  task automatic testReadFetch;
    bit t; int w; bit sawMem = 0;
    doReset();
    sendReq(0, 4'd5, 2'd1, t);
    for (int i = 0; i < 6; i++) begin
      if (memReqValid) begin sawMem = 1; break; end
      @(negedge clk);
    end
    check(sawMem, "R3", "memReqValid raised", sawMem, 1);
    @(negedge clk);
    sendReq(0, 4'd6, 2'd2, t);         // waits behind the fetch
    expectQuiet("R10", 4);
    memRspValid = 1'b1; memRspData = 32'hCAFE_0123;
    @(negedge clk);
    memRspValid = 1'b0;
    expectMsg("R3", 2'd0, 4'b0010, 4'd5, 32'hCAFE_0123, w);
    expectMsg("R2", 2'd2, 4'b0010, 4'd6, 32'h0, w);   // root now on port 1
    sendAck(2'd1);                     // stray ack, no teardown
    sendAck(2'd1);
    sendReq(0, 4'd7, 2'd3, t);
    expectMsg("R9", 2'd2, 4'b0010, 4'd7, 32'h0, w);
    check(!memReqValid, "R9", "no memory fetch after stray ack", memReqValid, 0);
  endtask

  // R4
  task automatic testWriteNoTree;
    bit t; int w;
    doReset();
    sendReq(1, 4'd3, 2'd0, t);
    expectMsg("R4", 2'd1, 4'b0001, 4'd3, 32'h0, w);
    check(w == 2, "R4", "grant latency", w, 2);
    sendReq(0, 4'd4, 2'd2, t);
    expectMsg("R4", 2'd2, 4'b0001, 4'd4, 32'h0, w);
  endtask

  // R5, R6, R7, R8
  task automatic testTeardown;
    bit t; int w;
    doReset();
    sendReq(1, 4'd3, 2'd0, t);         // tree rooted at port 0
    expectMsg("R4", 2'd1, 4'b0001, 4'd3, 32'h0, w);
    sendReq(1, 4'd9, 2'd2, t);
    expectMsg("R5", 2'd3, 4'b0001, 4'd9, 32'h0, w);
    for (int k = 0; k < 4; k++) begin
      sendReq(0, 4'(10 + k), 2'd3, t);
      check(t, "R8", "queue accepts", t, 1);
    end
    check(reqReady == 1'b0, "R8", "reqReady low when full", reqReady, 0);
    sendReq(0, 4'd15, 2'd3, t);
    check(!t, "R8", "fifth request refused", t, 0);
    expectQuiet("R6", 5);
    sendAck(2'd0);
    expectMsg("R6", 2'd1, 4'b0100, 4'd9, 32'h0, w);
    for (int k = 0; k < 4; k++)
      expectMsg("R7", 2'd2, 4'b0100, 4'(10 + k), 32'h0, w);
    expectQuiet("R8", 4);              // refused request never served
  endtask

  initial begin
    testReset();
    testReadFetch();
    testWriteNoTree();
    testTeardown();
    finishUp();
  end
endmodule